// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block divides a fast input clock by a programmable integer. Each output period has two parts. The high part lasts N+1 input cycles and the low part lasts M+1 input cycles, so the ratio is N+M+2. A synchronizing input restarts the output in a known way. While it is held, the output stays at a chosen level. Once it is released, the output starts from that level after a programmable coarse delay of 0 to 31 input cycles.

For odd ratios built as M = N+1, an optional duty corrector stretches each high part by half an input cycle. It does this with a register clocked on the falling edge of the input clock, which gives an even duty cycle. A bypass setting gives a ratio of one by passing the input clock through.

A second divider stage follows the first and counts whole periods of the first stage. The overall ratio is then the product of the two stage ratios. All settings are copied into the stages only while sync is high. Changes made at other times therefore cannot produce runt pulses.

The block has no data streams and so no valid/ready interface. Every pin is a plain control level or a clock.

Top module: `pdiv_clock_divider`

## Requirements
- R1: After reset, clk_out stays low until a sync pulse has been applied and released. The configuration inputs have no effect before that.
- R2: Let edge k be the last rising clk edge at which sync is sampled high. After each edge that samples sync high, clk_out holds static at the cfg_start_high level.
- R3: In steady state, the first stage drives clk_out high for cfg_hi_len+1 cycles and low for cfg_lo_len+1 cycles. Both fields are 5 bits with cfg_hi_len+cfg_lo_len <= 30, which gives ratios of 2 to 32.
- R4: The first segment after edge k is at the start level, 1 = high and 0 = low. If the start level is high, the high length comes first; if low, the low length comes first.
- R5: cfg_delay (0..31) lengthens that first segment by cfg_delay cycles. The first transition falls at edge k + cfg_delay + first length.
- R6: With cfg_dcc_en = 1 and cfg_lo_len = cfg_hi_len+1, each high part is stretched to include the first half cycle of the following low segment. High and low then both last cfg_hi_len+1.5 cycles.
- R7: cfg_dcc_en has no effect when cfg_lo_len differs from cfg_hi_len+1.
- R8: With cfg_bypass = 1, the first stage divides by 1. From edge k+1 its output equals clk, and between edges k and k+1 it holds the start level. The length and delay fields are ignored.
- R9: Changes on any cfg input while sync is low have no effect on clk_out until the next sync release.
- R10: With cfg2_bypass = 0, the second stage counts first-stage periods D1, each measured from the first stage's entry into its start level. clk_out is high for (cfg2_hi_len+1)·D1 cycles and low for (cfg2_lo_len+1)·D1 cycles, beginning at the start level. With cfg2_bypass = 1, clk_out is the first-stage output.
- R11: With the first stage bypassed and the second active, clk_out divides clk by cfg2_hi_len+cfg2_lo_len+2. Its transitions fall at edge k + (cfg2_hi_len+1) and at later edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync | input | 1 | Synchronous hold/restart; settings are copied while high |
| cfg_hi_len | input | 5 | First stage high length minus one (N) |
| cfg_lo_len | input | 5 | First stage low length minus one (M) |
| cfg_delay | input | 5 | Coarse start delay in input cycles |
| cfg_start_high | input | 1 | Start level after release, 1 = high |
| cfg_bypass | input | 1 | First stage divides by one |
| cfg_dcc_en | input | 1 | Enable half-cycle duty correction |
| cfg2_hi_len | input | 5 | Second stage high length minus one |
| cfg2_lo_len | input | 5 | Second stage low length minus one |
| cfg2_bypass | input | 1 | Second stage passes the first stage output |
| clk_out | output | 1 | Divided clock |

## Verification
The bench samples clk_out in both halves of every input cycle, so a half-cycle error in the duty corrector shows up directly. A corrector that ignored the M = N+1 rule would stretch high parts that should stay whole. A design that applied settings without waiting for sync would change the period in the middle of a run. The boundary cases are ratio 2, ratio 32 and the maximum delay of 31. An off-by-one in a counter reload would shift every later edge by one cycle. The cascade is run both with a start delay and with a bypassed first stage. A second stage that counted the wrong first-stage event would come out with the wrong phase or period.

// File: rtl/pdiv_pkg.sv
package pdiv_pkg;
  localparam int unsigned PDIV_CW = 5;

  typedef struct packed {
    logic [PDIV_CW-1:0] hi_len;
    logic [PDIV_CW-1:0] lo_len;
    logic [PDIV_CW-1:0] delay;
    logic               start_high;
    logic               bypass;
    logic               dcc_en;
  } pdiv_cfg_t;
endpackage

// File: rtl/pdiv_stage.sv
module pdiv_stage
  import pdiv_pkg::*;
#(
  parameter int unsigned CW = PDIV_CW
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sync,
  input  logic      tick,
  input  pdiv_cfg_t cfg,
  output logic      lvl,
  output logic      run,
  output logic      wrap,
  output logic      start_q,
  output logic      bypass_q,
  output logic      dcc_act
);
  pdiv_cfg_t     cfg_q;
  logic          armed;
  logic [CW-1:0] phase_cnt;
  logic [CW-1:0] seg_cnt;
  logic [CW:0]   hi_plus1;
  logic          active;

  assign active   = armed && !sync;
  assign start_q  = cfg_q.start_high;
  assign bypass_q = cfg_q.bypass;
  assign hi_plus1 = {1'b0, cfg_q.hi_len} + {{CW{1'b0}}, 1'b1};
  assign dcc_act  = cfg_q.dcc_en && (hi_plus1 == {1'b0, cfg_q.lo_len});

  // a new period begins (entry into the start level) at the coming edge
  always_comb begin
    if (cfg_q.bypass) wrap = active && tick;
    else wrap = active && tick && (phase_cnt == '0) && (seg_cnt == '0)
                && (lvl != cfg_q.start_high);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      armed     <= 1'b0;
      run       <= 1'b0;
      lvl       <= 1'b0;
      phase_cnt <= '0;
      seg_cnt   <= '0;
    end else if (sync) begin
      cfg_q     <= cfg;
      armed     <= 1'b1;
      run       <= 1'b0;
      lvl       <= cfg.start_high;
      phase_cnt <= cfg.delay;
      seg_cnt   <= cfg.start_high ? cfg.hi_len : cfg.lo_len;
    end else if (armed) begin
      run <= 1'b1;
      if (tick && !cfg_q.bypass) begin
        if (phase_cnt != '0) begin
          phase_cnt <= phase_cnt - 1'b1;
        end else if (seg_cnt != '0) begin
          seg_cnt <= seg_cnt - 1'b1;
        end else begin
          lvl     <= !lvl;
          seg_cnt <= lvl ? cfg_q.lo_len : cfg_q.hi_len;
        end
      end
    end
  end

  // R2: sync forces the start level and stops the running state
  a_r2_sync_level: assert property (@(posedge clk) disable iff (!rst_n)
    sync |=> (lvl == start_q) && !run);

  // R3: the segment counter never exceeds the length of the current level
  a_r3_seg_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !cfg_q.bypass) |-> (seg_cnt <= (lvl ? cfg_q.hi_len : cfg_q.lo_len)));

  // R4: a wrap always lands in the start level
  a_r4_wrap_into_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !cfg_q.bypass) |=> (lvl == start_q));

  // R5: while the delay counts down the level does not move
  a_r5_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (active && tick && !cfg_q.bypass && (phase_cnt != '0)) |=> $stable(lvl));

  // R9: settings are frozen outside sync
  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync) |=> $stable(cfg_q));

  // R10: the level only steps on a tick
  a_r10_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync && !tick) |=> $stable(lvl));
endmodule

// File: rtl/pdiv_outsel.sv
module pdiv_outsel (
  input  logic clk,
  input  logic rst_n,
  input  logic src,
  input  logic lvl,
  input  logic run,
  input  logic start_q,
  input  logic bypass_q,
  input  logic dcc_act,
  output logic out
);
  logic lvl_neg;

  // half-cycle delayed copy used to stretch the high part
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) lvl_neg <= 1'b0;
    else        lvl_neg <= lvl;
  end

  always_comb begin
    if (bypass_q) out = run ? src : start_q;
    else          out = lvl | (dcc_act & lvl_neg);
  end

  // R6: the stretched output is high whenever the level register is
  a_r6_stretch_keeps_high: assert property (@(negedge clk) disable iff (!rst_n)
    (!bypass_q && dcc_act && $past(lvl)) |-> lvl_neg);
endmodule

// File: rtl/pdiv_clock_divider.sv
module pdiv_clock_divider
  import pdiv_pkg::*;
#(
  parameter bit CASCADE = 1'b1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sync,
  input  logic [PDIV_CW-1:0] cfg_hi_len,
  input  logic [PDIV_CW-1:0] cfg_lo_len,
  input  logic [PDIV_CW-1:0] cfg_delay,
  input  logic               cfg_start_high,
  input  logic               cfg_bypass,
  input  logic               cfg_dcc_en,
  input  logic [PDIV_CW-1:0] cfg2_hi_len,
  input  logic [PDIV_CW-1:0] cfg2_lo_len,
  input  logic               cfg2_bypass,
  output logic               clk_out
);
  localparam int unsigned CW = PDIV_CW;

  pdiv_cfg_t cfg1;
  logic lvl1, run1, wrap1, start1, byp1, dcc1, out1;

  always_comb begin
    cfg1.hi_len     = cfg_hi_len;
    cfg1.lo_len     = cfg_lo_len;
    cfg1.delay      = cfg_delay;
    cfg1.start_high = cfg_start_high;
    cfg1.bypass     = cfg_bypass;
    cfg1.dcc_en     = cfg_dcc_en;
  end

  pdiv_stage #(.CW(CW)) u_stage1 (
    .clk(clk), .rst_n(rst_n), .sync(sync), .tick(1'b1), .cfg(cfg1),
    .lvl(lvl1), .run(run1), .wrap(wrap1), .start_q(start1),
    .bypass_q(byp1), .dcc_act(dcc1)
  );

  pdiv_outsel u_out1 (
    .clk(clk), .rst_n(rst_n), .src(clk), .lvl(lvl1), .run(run1),
    .start_q(start1), .bypass_q(byp1), .dcc_act(dcc1), .out(out1)
  );

  generate
    if (CASCADE) begin : g_chain
      pdiv_cfg_t cfg2;
      logic lvl2, run2, wrap2, start2, byp2, dcc2;

      always_comb begin
        cfg2.hi_len     = cfg2_hi_len;
        cfg2.lo_len     = cfg2_lo_len;
        cfg2.delay      = '0;
        cfg2.start_high = cfg_start_high;
        cfg2.bypass     = cfg2_bypass;
        cfg2.dcc_en     = 1'b0;
      end

      pdiv_stage #(.CW(CW)) u_stage2 (
        .clk(clk), .rst_n(rst_n), .sync(sync), .tick(wrap1), .cfg(cfg2),
        .lvl(lvl2), .run(run2), .wrap(wrap2), .start_q(start2),
        .bypass_q(byp2), .dcc_act(dcc2)
      );

      pdiv_outsel u_out2 (
        .clk(clk), .rst_n(rst_n), .src(out1), .lvl(lvl2), .run(run2),
        .start_q(start2), .bypass_q(byp2), .dcc_act(dcc2), .out(clk_out)
      );

      // R10: the second stage advances only when the first stage wraps
      a_r10_chain_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync && !wrap1) |=> $stable(lvl2));
    end else begin : g_single
      assign clk_out = out1;
    end
  endgenerate
endmodule

// File: tb/sim_pdiv_clock_divider.sv
module sim_pdiv_clock_divider;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sync = 1'b0;
  logic [4:0] cfg_hi_len = '0, cfg_lo_len = '0, cfg_delay = '0;
  logic       cfg_start_high = 1'b0, cfg_bypass = 1'b0, cfg_dcc_en = 1'b0;
  logic [4:0] cfg2_hi_len = '0, cfg2_lo_len = '0;
  logic       cfg2_bypass = 1'b1;
  logic       clk_out;

  int checks = 0;
  int errors = 0;

  // expected configuration (what the last sync captured)
  int ex_n, ex_m, ex_p, ex_n2, ex_m2;
  logic ex_s, ex_b1, ex_b2, ex_dcc;
  // optional late change applied right after release (R9)
  logic late_change = 1'b0;

  always #10 clk = ~clk;

  pdiv_clock_divider u0 (
    .clk(clk), .rst_n(rst_n), .sync(sync),
    .cfg_hi_len(cfg_hi_len), .cfg_lo_len(cfg_lo_len), .cfg_delay(cfg_delay),
    .cfg_start_high(cfg_start_high), .cfg_bypass(cfg_bypass), .cfg_dcc_en(cfg_dcc_en),
    .cfg2_hi_len(cfg2_hi_len), .cfg2_lo_len(cfg2_lo_len), .cfg2_bypass(cfg2_bypass),
    .clk_out(clk_out)
  );

  function automatic logic seg_lvl(int t, logic s, int p, int nh, int ml);
    int l0, d, first_other;
    if (t < 0) return s;
    l0 = p + (s ? nh + 1 : ml + 1);
    if (t < l0) return s;
    t = t - l0;
    d = nh + ml + 2;
    t = t % d;
    first_other = s ? ml + 1 : nh + 1;
    return (t < first_other) ? !s : s;
  endfunction

  function automatic logic lvl1_at(int c);
    return seg_lvl(c, ex_s, ex_p, ex_n, ex_m);
  endfunction

  function automatic logic lvl2_at(int c);
    int ticks, d1;
    if (ex_b1) ticks = c;
    else begin
      d1 = ex_n + ex_m + 2;
      ticks = (c < ex_p) ? 0 : (c - ex_p) / d1;
    end
    return seg_lvl(ticks, ex_s, 0, ex_n2, ex_m2);
  endfunction

  // expected value in the first (h=0) or second (h=1) half of cycle c
  function automatic logic exp_out(int c, int h);
    logic dcc_eff;
    dcc_eff = ex_dcc && (ex_m == ex_n + 1);
    if (!ex_b2) return lvl2_at(c);
    if (ex_b1) return (c == 0) ? ex_s : (h == 0);
    if (h == 1) return lvl1_at(c);
    return lvl1_at(c) | (dcc_eff & lvl1_at(c - 1));
  endfunction

  task automatic set_cfg(int n, int m, int p, logic s, logic b1, logic dcc,
                         int n2, int m2, logic b2);
    cfg_hi_len = 5'(n); cfg_lo_len = 5'(m); cfg_delay = 5'(p);
    cfg_start_high = s; cfg_bypass = b1; cfg_dcc_en = dcc;
    cfg2_hi_len = 5'(n2); cfg2_lo_len = 5'(m2); cfg2_bypass = b2;
    ex_n = n; ex_m = m; ex_p = p; ex_s = s; ex_b1 = b1; ex_dcc = dcc;
    ex_n2 = n2; ex_m2 = m2; ex_b2 = b2;
  endtask

  task automatic report(string tag, int bad, int fc, int fh, logic act, logic exv);
    checks++;
    if (bad != 0) begin
      errors++;
      $display("FAIL %s: %0d mismatching samples, first at cycle %0d half %0d actual=%0b expected=%0b",
               tag, bad, fc, fh, act, exv);
    end
  endtask

  // pulse sync, release just after edge k, then compare ncyc cycles
  task automatic sync_and_compare(string tag, int ncyc);
    int bad, fc, fh;
    logic fa, fe, a;
    bad = 0; fc = 0; fh = 0; fa = 1'b0; fe = 1'b0;
    @(negedge clk) sync = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 sync = 1'b0;
    if (late_change) begin
      cfg_hi_len = 5'd7; cfg_lo_len = 5'd2; cfg_delay = 5'd4;
      cfg_start_high = !cfg_start_high; cfg_dcc_en = 1'b1;
    end
    for (int c = 0; c < ncyc; c++) begin
      if (c == 0) #4; else begin @(posedge clk); #5; end
      a = clk_out;
      if (a !== exp_out(c, 0)) begin
        if (bad == 0) begin fc = c; fh = 0; fa = a; fe = exp_out(c, 0); end
        bad++;
      end
      #10;
      a = clk_out;
      if (a !== exp_out(c, 1)) begin
        if (bad == 0) begin fc = c; fh = 1; fa = a; fe = exp_out(c, 1); end
        bad++;
      end
    end
    report(tag, bad, fc, fh, fa, fe);
  endtask

  task automatic t_reset_idle();
    int bad;
    bad = 0;
    cfg_start_high = 1'b1; cfg_bypass = 1'b1; cfg_hi_len = 5'd3;
    for (int c = 0; c < 10; c++) begin
      @(posedge clk); #5;
      if (clk_out !== 1'b0) bad++;
      #10;
      if (clk_out !== 1'b0) bad++;
    end
    report("R1 reset idle low", bad, 0, 0, clk_out, 1'b0);
  endtask

  task automatic t_hold_in_sync(logic s, logic b1);
    int bad;
    bad = 0;
    set_cfg(2, 3, 0, s, b1, 1'b1, 0, 0, 1'b1);
    @(negedge clk) sync = 1'b1;
    @(posedge clk);
    for (int c = 0; c < 6; c++) begin
      @(posedge clk); #5;
      if (clk_out !== s) bad++;
      #10;
      if (clk_out !== s) bad++;
    end
    @(negedge clk) sync = 1'b0;
    report(b1 ? "R2 R8 hold in sync bypass" : "R2 hold in sync", bad, 0, 0, clk_out, s);
  endtask

  task automatic t_basic();
    set_cfg(1, 2, 0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R3 R4 start high n1 m2", 20);
    set_cfg(2, 0, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R3 R4 start low n2 m0", 20);
  endtask

  task automatic t_limits();
    set_cfg(0, 0, 0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R3 ratio 2", 12);
    set_cfg(15, 15, 0, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R3 ratio 32", 70);
  endtask

  task automatic t_delay();
    set_cfg(1, 1, 3, 1'b1, 1'b0, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R5 delay 3", 20);
    set_cfg(0, 2, 31, 1'b0, 1'b0, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R5 delay 31", 45);
  endtask

  task automatic t_dcc();
    set_cfg(1, 2, 0, 1'b1, 1'b0, 1'b1, 0, 0, 1'b1);
    sync_and_compare("R6 correction ratio 5", 20);
    set_cfg(0, 1, 2, 1'b0, 1'b0, 1'b1, 0, 0, 1'b1);
    sync_and_compare("R6 correction ratio 3 start low", 20);
  endtask

  task automatic t_dcc_ignored();
    set_cfg(1, 1, 0, 1'b1, 1'b0, 1'b1, 0, 0, 1'b1);
    sync_and_compare("R7 correction ignored m=n", 16);
    set_cfg(2, 1, 0, 1'b1, 1'b0, 1'b1, 0, 0, 1'b1);
    sync_and_compare("R7 correction ignored m<n", 16);
  endtask

  task automatic t_bypass();
    set_cfg(3, 4, 5, 1'b1, 1'b1, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R8 bypass start high", 10);
    set_cfg(3, 4, 5, 1'b0, 1'b1, 1'b0, 0, 0, 1'b1);
    sync_and_compare("R8 bypass start low", 10);
  endtask

  task automatic t_frozen();
    set_cfg(1, 2, 0, 1'b1, 1'b0, 1'b0, 0, 0, 1'b1);
    late_change = 1'b1;
    sync_and_compare("R9 late change ignored", 30);
    late_change = 1'b0;
    ex_n = 7; ex_m = 2; ex_p = 4; ex_s = 1'b0; ex_dcc = 1'b1;
    sync_and_compare("R9 change applied at next sync", 30);
  endtask

  task automatic t_cascade();
    set_cfg(1, 0, 0, 1'b1, 1'b0, 1'b0, 1, 1, 1'b0);
    sync_and_compare("R10 cascade 3x4", 40);
    set_cfg(0, 1, 2, 1'b0, 1'b0, 1'b0, 0, 2, 1'b0);
    sync_and_compare("R10 cascade 3x4 delay start low", 45);
  endtask

  task automatic t_chain_bypass();
    set_cfg(6, 6, 9, 1'b1, 1'b1, 1'b0, 2, 1, 1'b0);
    sync_and_compare("R11 first bypass second divide 5", 24);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset_idle();
    t_hold_in_sync(1'b1, 1'b0);
    t_hold_in_sync(1'b0, 1'b0);
    t_hold_in_sync(1'b1, 1'b1);
    t_basic();
    t_limits();
    t_delay();
    t_dcc();
    t_dcc_ignored();
    t_bypass();
    t_frozen();
    t_cascade();
    t_chain_bypass();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule